// File: doc/BRIEF.md
# Fixed-point fractional quotient divider

This block divides one 32-bit unsigned word by another and returns the quotient as an unsigned fixed-point number. The upper 32 bits are the integer part and the lower 32 bits are the fraction. A plain integer divider throws the fraction away into a remainder. Here the numerator is first given 32 zero fraction bits, so the quotient of the 64-bit widened numerator carries the fraction directly, and no stage wider than 64 bits is needed.

The unit needs no start strobe. It compares both input words against the values it sampled on the previous clock. A difference on either word starts a division on the captured operands. The division is restoring, radix-2, with two quotient bits resolved each clock. A result appears a fixed 32 clocks after the start, marked by a one-cycle `valid_o` pulse. While a division runs, the inputs may keep moving. The running division is not disturbed. A change seen during the run is remembered and starts a fresh division as soon as the unit is idle again. A zero denominator completes in the usual time, returns all ones and raises a flag.

Top module: `fxq_divider`

## Requirements
- R1: While `rst_n` is low, `busy_o`, `valid_o` and `dbz_o` are 0 and `quot_o` is all zeros.
- R2: When idle, a clock edge at which `num_i` or `den_i` (either one alone is enough) differs from its value at the previous edge starts a division, and `busy_o` is high from that edge on.
- R3: `valid_o` is high for exactly one cycle, on the 32nd edge after the start edge, and `busy_o` falls on that same edge.
- R4: With `valid_o` high and a nonzero denominator, `quot_o` equals floor(num * 2^32 / den). Bits 63..32 hold the integer part and bits 31..0 the fraction. Lower fraction bits are truncated, not rounded.
- R5: `quot_o` keeps its value in every cycle where `valid_o` is low.
- R6: The operands are captured on the start edge. Input changes during a running division do not change its result.
- R7: An input change seen while busy starts a new division on the first idle edge after completion, using the inputs present at that edge.
- R8: A zero denominator completes with the normal latency, gives `quot_o` all ones and raises `dbz_o`. `dbz_o` is high only together with `valid_o`.
- R9: While idle, inputs held constant start no division, so `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| num_i | input | 32 | Numerator, unsigned integer |
| den_i | input | 32 | Denominator, unsigned integer |
| quot_o | output | 64 | Quotient, unsigned 32.32 fixed point |
| valid_o | output | 1 | One-cycle pulse, quotient updated |
| busy_o | output | 1 | Division in progress |
| dbz_o | output | 1 | Completed division had a zero denominator |

## Verification
A wrong state in the controller shows at the ports within one cycle of its cause. If the iteration count is off, `valid_o` lands on the wrong edge. If the change detector misfires, `busy_o` rises when it should not, or fails to rise. A lost pending request shows as a missing second result 33 cycles later. A fault in the remainder or shift path stays hidden until completion and then appears as a wrong `quot_o` value. For that reason the operand pairs are chosen so that each gives a distinct pattern in the integer bits, in the fraction bits, or in both.

// File: rtl/fxq_pkg.sv
package fxq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fxq_state_e;
endpackage

// File: rtl/fxq_change_det.sv
module fxq_change_det #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         changed_o
);
  logic [W-1:0] num_prev_q;
  logic [W-1:0] den_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_prev_q <= '0;
      den_prev_q <= '0;
    end else begin
      num_prev_q <= num_i;
      den_prev_q <= den_i;
    end
  end

  // each word compared on its own; either one triggers
  assign changed_o = (num_i != num_prev_q) || (den_i != den_prev_q);
endmodule

// File: rtl/fxq_rstep.sv
module fxq_rstep #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] rem_i,
  input  logic          bit_i,
  input  logic [DW-1:0] den_i,
  output logic [DW-1:0] rem_o,
  output logic          qbit_o
);
  logic [DW:0] trial;

  always_comb begin
    trial  = {rem_i, bit_i};
    qbit_o = (trial >= {1'b0, den_i});
    // the true difference is below den, so DW bits hold it
    rem_o  = qbit_o ? (trial[DW-1:0] - den_i) : trial[DW-1:0];
  end
endmodule

// File: rtl/fxq_datapath.sv
module fxq_datapath #(
  parameter int W    = 32,
  parameter int FRAC = 32,
  parameter int SPC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             done_i,
  input  logic [W-1:0]     num_i,
  input  logic [W-1:0]     den_i,
  output logic [W+FRAC-1:0] quot_o,
  output logic             dbz_o
);
  localparam int QW = W + FRAC;

  logic [QW-1:0]  work_q;
  logic [QW-1:0]  work_d;
  logic [W-1:0]   rem_q;
  logic [W-1:0]   den_q;
  logic [QW-1:0]  quot_q;
  logic           dbz_q;
  logic [W-1:0]   rem_c [SPC+1];
  logic [SPC-1:0] qbits;

  assign rem_c[0] = rem_q;

  generate
    for (genvar k = 0; k < SPC; k++) begin : g_step
      fxq_rstep #(.DW(W)) i_step (
        .rem_i  (rem_c[k]),
        .bit_i  (work_q[QW-1-k]),
        .den_i  (den_q),
        .rem_o  (rem_c[k+1]),
        .qbit_o (qbits[SPC-1-k])
      );
    end
  endgenerate

  // dividend bits leave at the top, quotient bits enter at the bottom
  assign work_d = {work_q[QW-SPC-1:0], qbits};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      rem_q  <= '0;
      den_q  <= '0;
    end else if (load_i) begin
      work_q <= {num_i, {FRAC{1'b0}}};
      rem_q  <= '0;
      den_q  <= den_i;
    end else if (step_i) begin
      work_q <= work_d;
      rem_q  <= rem_c[SPC];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot_q <= '0;
    end else if (done_i) begin
      quot_q <= work_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbz_q <= 1'b0;
    end else begin
      dbz_q <= done_i && (den_q == '0);
    end
  end

  assign quot_o = quot_q;
  assign dbz_o  = dbz_q;
endmodule

// File: rtl/fxq_ctrl.sv
module fxq_ctrl
  import fxq_pkg::*;
#(
  parameter int LAT = 32,
  parameter int CW  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic changed_i,
  output logic start_o,
  output logic step_o,
  output logic done_o,
  output logic valid_o
);
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  fxq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          valid_q;
  logic          start, done;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    start   = 1'b0;
    done    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        pend_d = 1'b0;
        if (changed_i || pend_q) begin
          start   = 1'b1;
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (changed_i) pend_d = 1'b1;
        if (cnt_q == LAST) begin
          done    = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      valid_q <= done;
    end
  end

  assign start_o = start;
  assign done_o  = done;
  assign step_o  = (state_q == ST_RUN);
  assign valid_o = valid_q;
endmodule

// File: rtl/fxq_divider.sv
module fxq_divider #(
  parameter int W    = 32,
  parameter int FRAC = 32,
  parameter int SPC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      num_i,
  input  logic [W-1:0]      den_i,
  output logic [W+FRAC-1:0] quot_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              dbz_o
);
  localparam int QW  = W + FRAC;
  localparam int LAT = QW / SPC;
  localparam int CW  = (LAT > 1) ? $clog2(LAT) : 1;

  logic changed, start, step, done;

  fxq_change_det #(.W(W)) i_chg (
    .clk       (clk),
    .rst_n     (rst_n),
    .num_i     (num_i),
    .den_i     (den_i),
    .changed_o (changed)
  );

  fxq_ctrl #(.LAT(LAT), .CW(CW)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .changed_i (changed),
    .start_o   (start),
    .step_o    (step),
    .done_o    (done),
    .valid_o   (valid_o)
  );

  fxq_datapath #(.W(W), .FRAC(FRAC), .SPC(SPC)) i_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start),
    .step_i (step),
    .done_i (done),
    .num_i  (num_i),
    .den_i  (den_i),
    .quot_o (quot_o),
    .dbz_o  (dbz_o)
  );

  assign busy_o = step;
endmodule

// File: rtl/fxq_divider_chk.sv
module fxq_divider_chk #(
  parameter int QW  = 64,
  parameter int LAT = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [QW-1:0] quot_o,
  input logic          valid_o,
  input logic          busy_o,
  input logic          dbz_o
);
  localparam int RW = $clog2(LAT) + 2;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);                                     // R3
  AST_VALID_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !busy_o);                                      // R3
  AST_BUSY_FALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> valid_o);                                // R3
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (run_q == RW'(LAT)));                          // R3
  AST_QUOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(quot_o));                             // R5
  AST_DBZ_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dbz_o |-> valid_o);                                        // R8
  AST_DBZ_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    dbz_o |-> (quot_o == {QW{1'b1}}));                         // R8
endmodule

bind fxq_divider fxq_divider_chk #(.QW(QW), .LAT(LAT)) i_fxq_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .quot_o  (quot_o),
  .valid_o (valid_o),
  .busy_o  (busy_o),
  .dbz_o   (dbz_o)
);

// File: tb/test_fxq_divider.sv
`timescale 1ns/1ps
module test_fxq_divider;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] num_r, den_r;
  logic [63:0] quot;
  logic        valid, busy, dbz;

  int vectors = 0;
  int fails   = 0;
  bit ended   = 0;

  // behavioural reference state
  logic [31:0] m_pn, m_pd, m_on, m_od;
  logic [63:0] m_q;
  logic        m_busy, m_valid, m_dbz, m_pend;
  int          m_cnt;

  always #2.5 clk = ~clk;

  fxq_divider i_fxq_divider (
    .clk(clk), .rst_n(rst_n), .num_i(num_r), .den_i(den_r),
    .quot_o(quot), .valid_o(valid), .busy_o(busy), .dbz_o(dbz)
  );

  function automatic logic [63:0] ref_div(input logic [31:0] n, input logic [31:0] d);
    logic [63:0] wide;
    wide = {n, 32'h0};
    if (d == 0) return {64{1'b1}};
    return wide / {32'h0, d};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit ch;
    if (!rst_n) begin
      m_pn = 0; m_pd = 0; m_q = 0; m_busy = 0; m_valid = 0;
      m_dbz = 0; m_pend = 0; m_cnt = 0;
      return;
    end
    ch = (num_r != m_pn) || (den_r != m_pd);
    m_valid = 0; m_dbz = 0;
    if (!m_busy) begin
      if (ch || m_pend) begin
        m_busy = 1; m_cnt = 0; m_on = num_r; m_od = den_r; m_pend = 0;
      end
    end else begin
      if (ch) m_pend = 1;
      if (m_cnt == 31) begin
        m_busy = 0; m_valid = 1; m_q = ref_div(m_on, m_od); m_dbz = (m_od == 0);
      end else m_cnt++;
    end
    m_pn = num_r; m_pd = den_r;
  endtask

  // one clock with the given inputs; compare at the following falling edge
  task automatic cyc(input logic [31:0] n, input logic [31:0] d);
    num_r = n; den_r = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R2 busy_o", {63'h0, busy}, {63'h0, m_busy});
    chk("R3 valid_o", {63'h0, valid}, {63'h0, m_valid});
    chk("R4 quot_o", quot, m_q);
    chk("R8 dbz_o", {63'h0, dbz}, {63'h0, m_dbz});
  endtask

  // hold inputs until a result appears; return it and the cycle count
  task automatic run_op(input logic [31:0] n, input logic [31:0] d,
                        output logic [63:0] q, output int lat);
    lat = 0;
    do begin
      cyc(n, d);
      lat++;
    end while (!valid && lat < 100);
    q = quot;
  endtask

  initial begin
    logic [63:0] q;
    int lat;
    logic [31:0] seed;
    rst_n = 1'b0; num_r = 0; den_r = 0;
    repeat (3) cyc(0, 0);
    // R1 reset state
    chk("R1 reset busy", {63'h0, busy}, 64'h0);
    chk("R1 reset valid", {63'h0, valid}, 64'h0);
    chk("R1 reset dbz", {63'h0, dbz}, 64'h0);
    chk("R1 reset quot", quot, 64'h0);
    rst_n = 1'b1;

    // R9 constant inputs while idle start nothing
    repeat (8) cyc(0, 0);
    chk("R9 idle busy", {63'h0, busy}, 64'h0);

    // R4 fraction only; R3 latency of start edge plus 32
    run_op(1, 3, q, lat);
    chk("R4 1/3", q, 64'h0000_0000_5555_5555);
    chk("R3 latency", 64'(lat), 64'd33);
    cyc(1, 3);
    chk("R3 valid one cycle", {63'h0, valid}, 64'h0);
    // R5 result held
    repeat (5) cyc(1, 3);
    chk("R5 hold", quot, 64'h0000_0000_5555_5555);
    chk("R9 no restart", {63'h0, busy}, 64'h0);

    // R8 zero denominator
    run_op(7, 0, q, lat);
    chk("R8 div zero quot", q, {64{1'b1}});
    chk("R8 div zero flag", {63'h0, dbz}, 64'h1);
    chk("R8 latency", 64'(lat), 64'd33);

    // R2 denominator change alone
    run_op(7, 2, q, lat);
    chk("R2 den only 7/2", q, 64'h0000_0003_8000_0000);
    // R2 numerator change alone
    run_op(9, 2, q, lat);
    chk("R2 num only 9/2", q, 64'h0000_0004_8000_0000);

    // R4 full integer range
    run_op(32'hFFFF_FFFF, 1, q, lat);
    chk("R4 max/1", q, 64'hFFFF_FFFF_0000_0000);
    run_op(1, 32'hFFFF_FFFF, q, lat);
    chk("R4 1/max", q, 64'h0000_0000_0000_0001);

    // R6 change while busy; R7 pending restart
    repeat (5) cyc(10, 4);
    run_op(1, 8, q, lat);
    chk("R6 latched 10/4", q, 64'h0000_0002_8000_0000);
    cyc(1, 8);
    chk("R7 restart busy", {63'h0, busy}, 64'h1);
    run_op(1, 8, q, lat);
    chk("R7 pending 1/8", q, 64'h0000_0000_2000_0000);

    // mixed traffic against the model
    seed = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      if (seed[31:29] == 3'd0)
        cyc(seed[27:0] ^ 28'h0A5_5A5A, {24'h0, seed[15:8]});
      else
        cyc(num_r, den_r);
    end

    ended = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule